// File: doc/BRIEF.md
# Multistage Ring Slot Controller

This block hands out the slots of a circular staging buffer to one producer group and one consumer group. Every slot carries two parity barriers. The fill barrier tells the consumer that the slot holds fresh data. The drain barrier tells the producer that the slot may be overwritten. The data storage lives outside the block. The controller only decides who may touch which slot, and when.

The producer acquires the slot under its cursor. The acquire arms that slot's fill barrier with the number of bytes the transfer will deliver. After that, producer threads report their arrivals and the transfer engine reports the bytes it has delivered. The fill barrier flips its phase once both totals are reached.

The consumer waits on the slot under its own cursor. It later releases slots through a third cursor. By default this release cursor trails the consumer by a fixed lag, so the oldest slot is freed only while a newer one is still in use. A drain input releases the remaining held slots at the end of a run.

The producer's cursor phase starts inverted. Because of this, the first lap of acquires passes without any release, and neither side can deadlock at start-up.

Top module: `ring_ctrl`

## Requirements
- R1: After reset the producer cursor is at slot 0 with phase 1. The consumer cursor is at slot 0 with phase 0. `prod_acq_ready` is 1, and `cons_wait_ready` and `cons_rel_ready` are 0.
- R2: `prod_acq_ready` is 1 exactly when fewer than SLOTS slots have been acquired and not yet freed. A slot is never granted again before its drain barrier has completed.
- R3: Each cursor steps through slots 0 to SLOTS-1 in turn. On moving past SLOTS-1 it returns to 0 and inverts its phase output.
- R4: A slot's fill barrier completes only when two conditions both hold, reached in either order. First, the producer arrivals (summed `prod_commit_num`) have reached `cfg_prod_arrivals`. Second, the delivered bytes (summed `tx_done_bytes`) equal the byte count armed at acquire. `cons_wait_ready` rises in the cycle after the edge that completes the barrier.
- R5: `cons_wait_ready` is 1 only while the slot under the consumer cursor is full. Slots reach the consumer in the order in which the producer acquired them.
- R6: A slot's drain barrier completes when the consumer arrivals (summed `cons_rel_num`) reach `cfg_cons_arrivals`. If the producer waits on that slot, `prod_acq_ready` rises in the cycle after.
- R7: `cons_rel_ready` is 1 when the number of waited-but-unfreed slots exceeds LAG. It is also 1 when `cons_drain` is high and at least one slot is held. `cons_rel_slot` always names the oldest held slot.
- R8: The producer and consumer arrival counts are independent settings. The handshake rules above hold for any pair of values from 1 upwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prod_arrivals | input | CNT_W | Producer arrivals needed per fill |
| cfg_cons_arrivals | input | CNT_W | Consumer arrivals needed per free |
| prod_acq_valid | input | 1 | Producer requests the next slot |
| prod_acq_bytes | input | BYTE_W | Bytes the transfer into this slot will deliver |
| prod_acq_ready | output | 1 | Slot under producer cursor may be overwritten |
| prod_slot | output | IDX_W | Producer cursor slot |
| prod_phase | output | 1 | Producer cursor phase |
| prod_commit_valid | input | 1 | Producer threads arrive on a fill barrier |
| prod_commit_slot | input | IDX_W | Slot of that arrival |
| prod_commit_num | input | CNT_W | Number of threads arriving |
| tx_done_valid | input | 1 | Transfer engine delivered bytes |
| tx_done_slot | input | IDX_W | Slot the bytes landed in |
| tx_done_bytes | input | BYTE_W | Bytes delivered |
| cons_wait_valid | input | 1 | Consumer takes the next full slot |
| cons_wait_ready | output | 1 | Slot under consumer cursor is full |
| cons_slot | output | IDX_W | Consumer cursor slot |
| cons_phase | output | 1 | Consumer cursor phase |
| cons_rel_valid | input | 1 | Consumer threads arrive on a drain barrier |
| cons_rel_num | input | CNT_W | Number of threads arriving |
| cons_rel_ready | output | 1 | A release may be presented |
| cons_rel_slot | output | IDX_W | Slot the next release frees |
| cons_drain | input | 1 | End of run: release regardless of lag |

## Verification
Every ready output is computed combinationally from registered barrier phases and cursors. A handshake that completes a barrier at a rising edge is therefore visible one edge later. The bench drives on the falling edge and samples one time unit after it, which lands exactly in the cycle the requirement names. A reference model in the bench counts acquires, waits and completed frees. From these counts it predicts every ready flag, the slot and phase of each cursor, and the acquire-order token each consumed slot must carry.

// File: rtl/ring_pkg.sv
package ring_pkg;
   // Width of an index addressing n entries (at least one bit).
   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // Width of a counter reaching n inclusive.
   function automatic int cnt_width(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/ring_cursor.sv
module ring_cursor #(
   parameter int  SLOTS      = 4,
   parameter bit  INIT_PHASE = 1'b0,
   localparam int IDX_W      = ring_pkg::idx_width(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic             phase
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx   <= '0;
         phase <= INIT_PHASE;
      end else if (adv) begin
         if (idx == LAST) begin
            idx   <= '0;
            phase <= ~phase;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && idx == LAST) |=> (idx == '0 && phase != $past(phase)));

   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && idx != LAST) |=> (idx == $past(idx) + 1'b1 && $stable(phase)));
endmodule

// File: rtl/ring_phase_barrier.sv
module ring_phase_barrier #(
   parameter int CNT_W    = 4,
   parameter int BYTE_W   = 12,
   parameter bit TRACK_TX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_need,
   input  logic              arrive_en,
   input  logic [CNT_W-1:0]  arrive_num,
   input  logic              expect_en,
   input  logic [BYTE_W-1:0] expect_bytes,
   input  logic              tx_en,
   input  logic [BYTE_W-1:0] tx_bytes,
   output logic              phase,
   output logic              complete
);
   logic [CNT_W:0] arr_q, arr_nx;
   logic           tx_ok;
   logic           any_event;

   assign arr_nx    = arr_q + (arrive_en ? {1'b0, arrive_num} : '0);
   assign any_event = arrive_en | tx_en | expect_en;

   generate
      if (TRACK_TX) begin : g_tx
         logic [BYTE_W:0] pend_q, pend_nx;
         logic            armed_q, armed_nx;

         assign pend_nx  = pend_q + (expect_en ? {1'b0, expect_bytes} : '0)
                                  - (tx_en ? {1'b0, tx_bytes} : '0);
         assign armed_nx = armed_q | expect_en;
         assign tx_ok    = armed_nx && (pend_nx == '0);

         always_ff @(posedge clk) begin
            if (!rst_n || complete) begin
               pend_q  <= '0;
               armed_q <= 1'b0;
            end else begin
               pend_q  <= pend_nx;
               armed_q <= armed_nx;
            end
         end

         // R4
         tx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_en |-> ({1'b0, tx_bytes} <= pend_q + (expect_en ? {1'b0, expect_bytes} : '0)));
      end else begin : g_no_tx
         logic unused_tx;
         assign unused_tx = ^{expect_en, expect_bytes, tx_en, tx_bytes};
         assign tx_ok     = 1'b1;
      end
   endgenerate

   assign complete = any_event && tx_ok && (arr_nx >= {1'b0, cfg_need});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arr_q <= '0;
         phase <= 1'b0;
      end else if (complete) begin
         arr_q <= '0;
         phase <= ~phase;
      end else begin
         arr_q <= arr_nx;
      end
   end
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl #(
   parameter int  SLOTS  = 4,
   parameter int  CNT_W  = 4,
   parameter int  BYTE_W = 12,
   parameter int  LAG    = 1,
   localparam int IDX_W  = ring_pkg::idx_width(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_prod_arrivals,
   input  logic [CNT_W-1:0]  cfg_cons_arrivals,
   input  logic              prod_acq_valid,
   input  logic [BYTE_W-1:0] prod_acq_bytes,
   output logic              prod_acq_ready,
   output logic [IDX_W-1:0]  prod_slot,
   output logic              prod_phase,
   input  logic              prod_commit_valid,
   input  logic [IDX_W-1:0]  prod_commit_slot,
   input  logic [CNT_W-1:0]  prod_commit_num,
   input  logic              tx_done_valid,
   input  logic [IDX_W-1:0]  tx_done_slot,
   input  logic [BYTE_W-1:0] tx_done_bytes,
   input  logic              cons_wait_valid,
   output logic              cons_wait_ready,
   output logic [IDX_W-1:0]  cons_slot,
   output logic              cons_phase,
   input  logic              cons_rel_valid,
   input  logic [CNT_W-1:0]  cons_rel_num,
   output logic              cons_rel_ready,
   output logic [IDX_W-1:0]  cons_rel_slot,
   input  logic              cons_drain
);
   localparam int OCC_W = ring_pkg::cnt_width(SLOTS);

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("ring_ctrl: SLOTS must be at least 2");
      end
      if (LAG < 0 || LAG >= SLOTS) begin : g_bad_lag
         $error("ring_ctrl: LAG must lie in 0..SLOTS-1");
      end
      if (CNT_W < 1 || BYTE_W < 1) begin : g_bad_width
         $error("ring_ctrl: widths must be positive");
      end
   endgenerate

   logic             acq_hs, wait_hs, rel_hs, free_done;
   logic [SLOTS-1:0] fill_ph, drain_ph, fill_done, drain_done;
   logic             unused_rel_phase;
   logic [OCC_W-1:0] occ_q, held_q;

   assign acq_hs  = prod_acq_valid & prod_acq_ready;
   assign wait_hs = cons_wait_valid & cons_wait_ready;
   assign rel_hs  = cons_rel_valid & cons_rel_ready;

   // Producer starts out of phase with the drain barriers so a full lap passes.
   ring_cursor #(.SLOTS(SLOTS), .INIT_PHASE(1'b1)) prod_cur_i (
      .clk(clk), .rst_n(rst_n), .adv(acq_hs), .idx(prod_slot), .phase(prod_phase));

   ring_cursor #(.SLOTS(SLOTS), .INIT_PHASE(1'b0)) cons_cur_i (
      .clk(clk), .rst_n(rst_n), .adv(wait_hs), .idx(cons_slot), .phase(cons_phase));

   ring_cursor #(.SLOTS(SLOTS), .INIT_PHASE(1'b0)) rel_cur_i (
      .clk(clk), .rst_n(rst_n), .adv(free_done), .idx(cons_rel_slot),
      .phase(unused_rel_phase));

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         ring_phase_barrier #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .TRACK_TX(1'b1)) fill_i (
            .clk(clk), .rst_n(rst_n),
            .cfg_need(cfg_prod_arrivals),
            .arrive_en(prod_commit_valid && prod_commit_slot == IDX_W'(s)),
            .arrive_num(prod_commit_num),
            .expect_en(acq_hs && prod_slot == IDX_W'(s)),
            .expect_bytes(prod_acq_bytes),
            .tx_en(tx_done_valid && tx_done_slot == IDX_W'(s)),
            .tx_bytes(tx_done_bytes),
            .phase(fill_ph[s]),
            .complete(fill_done[s]));

         ring_phase_barrier #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .TRACK_TX(1'b0)) drain_i (
            .clk(clk), .rst_n(rst_n),
            .cfg_need(cfg_cons_arrivals),
            .arrive_en(rel_hs && cons_rel_slot == IDX_W'(s)),
            .arrive_num(cons_rel_num),
            .expect_en(1'b0),
            .expect_bytes('0),
            .tx_en(1'b0),
            .tx_bytes('0),
            .phase(drain_ph[s]),
            .complete(drain_done[s]));
      end
   endgenerate

   // Parity wait: a side passes when the barrier phase differs from its own.
   assign prod_acq_ready  = drain_ph[prod_slot] != prod_phase;
   assign cons_wait_ready = fill_ph[cons_slot] != cons_phase;
   assign free_done       = |drain_done;

   assign cons_rel_ready = (held_q > OCC_W'(LAG)) || (cons_drain && held_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q  <= '0;
         held_q <= '0;
      end else begin
         occ_q  <= occ_q  + OCC_W'(acq_hs)  - OCC_W'(free_done);
         held_q <= held_q + OCC_W'(wait_hs) - OCC_W'(free_done);
      end
   end

   // R2
   prod_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_q == OCC_W'(SLOTS)) |-> !prod_acq_ready);

   // R5
   cons_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_hs |-> (occ_q > held_q));

   // R7
   rel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_hs |-> (held_q != '0));

   // R6
   held_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held_q <= occ_q);

   // R6
   single_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drain_done));
endmodule

// File: tb/ring_ctrl_tb_top.sv
module ring_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int S   = 4;
   localparam int CW  = 4;
   localparam int BW  = 12;
   localparam int LAG = 1;
   localparam int IW  = 2;

   // Scenario table: producer arrivals, consumer arrivals, bytes, run-ahead, items
   localparam int ROWS = 5;
   localparam int T_PROD [ROWS]  = '{1, 2, 3, 1, 2};
   localparam int T_CONS [ROWS]  = '{1, 1, 2, 3, 2};
   localparam int T_BYTES[ROWS]  = '{64, 128, 10, 300, 2};
   localparam int T_AHEAD[ROWS]  = '{1, 4, 2, 4, 3};
   localparam int T_ITEMS[ROWS]  = '{6, 10, 9, 11, 8};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_prod_arrivals = 4'd1, cfg_cons_arrivals = 4'd1;
   logic          prod_acq_valid = 1'b0;
   logic [BW-1:0] prod_acq_bytes = '0;
   logic          prod_acq_ready;
   logic [IW-1:0] prod_slot;
   logic          prod_phase;
   logic          prod_commit_valid = 1'b0;
   logic [IW-1:0] prod_commit_slot = '0;
   logic [CW-1:0] prod_commit_num = '0;
   logic          tx_done_valid = 1'b0;
   logic [IW-1:0] tx_done_slot = '0;
   logic [BW-1:0] tx_done_bytes = '0;
   logic          cons_wait_valid = 1'b0;
   logic          cons_wait_ready;
   logic [IW-1:0] cons_slot;
   logic          cons_phase;
   logic          cons_rel_valid = 1'b0;
   logic [CW-1:0] cons_rel_num = '0;
   logic          cons_rel_ready;
   logic [IW-1:0] cons_rel_slot;
   logic          cons_drain = 1'b0;

   int checks = 0;
   int fails  = 0;
   int tok [S];

   ring_ctrl #(.SLOTS(S), .CNT_W(CW), .BYTE_W(BW), .LAG(LAG)) dut_i (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog (run did not finish) actual=timeout expected=finish");
      summary();
      $finish;
   end

   task automatic do_reset(input int p, input int c);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_prod_arrivals = CW'(p);
      cfg_cons_arrivals = CW'(c);
      cons_drain = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic probe(input int exp_prod, input int exp_cons, input int exp_rel, input string tag);
      @(negedge clk);
      #1;
      chk({tag, " prod_acq_ready"}, int'(prod_acq_ready), exp_prod);
      chk({tag, " cons_wait_ready"}, int'(cons_wait_ready), exp_cons);
      chk({tag, " cons_rel_ready"}, int'(cons_rel_ready), exp_rel);
   endtask

   task automatic do_acq(input int bytes, output int slot);
      @(negedge clk);
      prod_acq_valid = 1'b1;
      prod_acq_bytes = BW'(bytes);
      #1;
      chk("R2 acquire granted", int'(prod_acq_ready), 1);
      slot = int'(prod_slot);
      @(posedge clk);
      #1 prod_acq_valid = 1'b0;
   endtask

   task automatic do_commit(input int slot, input int num);
      @(negedge clk);
      prod_commit_valid = 1'b1;
      prod_commit_slot  = IW'(slot);
      prod_commit_num   = CW'(num);
      @(posedge clk);
      #1 prod_commit_valid = 1'b0;
   endtask

   task automatic do_tx(input int slot, input int bytes);
      @(negedge clk);
      tx_done_valid = 1'b1;
      tx_done_slot  = IW'(slot);
      tx_done_bytes = BW'(bytes);
      @(posedge clk);
      #1 tx_done_valid = 1'b0;
   endtask

   task automatic do_wait(output int slot);
      @(negedge clk);
      cons_wait_valid = 1'b1;
      #1;
      chk("R5 wait granted", int'(cons_wait_ready), 1);
      slot = int'(cons_slot);
      @(posedge clk);
      #1 cons_wait_valid = 1'b0;
   endtask

   task automatic do_rel(input int num, output int slot);
      @(negedge clk);
      cons_rel_valid = 1'b1;
      cons_rel_num   = CW'(num);
      #1;
      chk("R7 release granted", int'(cons_rel_ready), 1);
      slot = int'(cons_rel_slot);
      @(posedge clk);
      #1 cons_rel_valid = 1'b0;
   endtask

   task automatic fill_slot(input int p, input int bytes, output int slot);
      do_acq(bytes, slot);
      for (int i = 0; i < p; i++) do_commit(slot, 1);
      do_tx(slot, bytes / 2);
      do_tx(slot, bytes - bytes / 2);
   endtask

   task automatic run_row(input int r);
      int p, c, bytes, ahead, n;
      int pc, cc, rc, slot, guard;
      bit drain;
      p = T_PROD[r]; c = T_CONS[r]; bytes = T_BYTES[r];
      ahead = T_AHEAD[r]; n = T_ITEMS[r];
      do_reset(p, c);
      pc = 0; cc = 0; rc = 0; drain = 1'b0; guard = 0;
      while (rc < n && guard < 500) begin
         guard++;
         cons_drain = drain;
         // R8: readiness follows the shared model for every arrival-count pair
         probe((pc - rc < S) ? 1 : 0, (cc < pc) ? 1 : 0,
               ((cc - rc > LAG) || (drain && cc - rc > 0)) ? 1 : 0, "R8 stream");
         if ((cc - rc > LAG) || (drain && cc - rc > 0)) begin
            for (int i = 0; i < c; i++) begin
               do_rel(1, slot);
               chk("R7 oldest slot released", slot, rc % S);
            end
            rc++;
         end else if (pc < n && pc - cc < ahead && pc - rc < S) begin
            @(negedge clk); #1;
            chk("R3 producer slot", int'(prod_slot), pc % S);
            chk("R3 producer phase", int'(prod_phase), ((pc / S) % 2 == 0) ? 1 : 0);
            fill_slot(p, bytes, slot);
            tok[slot] = pc;
            pc++;
         end else if (cc < pc) begin
            chk("R3 consumer phase", int'(cons_phase), ((cc / S) % 2 == 0) ? 0 : 1);
            do_wait(slot);
            chk("R5 consumer slot", slot, cc % S);
            chk("R5 production order", tok[slot], cc);
            cc++;
         end else begin
            drain = 1'b1;
         end
      end
      cons_drain = 1'b0;
      chk("R8 row completed", rc, n);
   endtask

   initial begin
      int slot;
      // R1: reset state
      do_reset(2, 1);
      @(negedge clk); #1;
      chk("R1 prod_acq_ready", int'(prod_acq_ready), 1);
      chk("R1 cons_wait_ready", int'(cons_wait_ready), 0);
      chk("R1 cons_rel_ready", int'(cons_rel_ready), 0);
      chk("R1 prod_slot", int'(prod_slot), 0);
      chk("R1 prod_phase", int'(prod_phase), 1);
      chk("R1 cons_slot", int'(cons_slot), 0);
      chk("R1 cons_phase", int'(cons_phase), 0);

      // R4: arrivals complete before bytes, and bytes before arrivals
      do_acq(64, slot);
      do_commit(slot, 1);
      probe(1, 0, 0, "R4 one of two arrivals");
      do_tx(slot, 64);
      probe(1, 0, 0, "R4 bytes done, arrivals short");
      do_commit(slot, 1);
      probe(1, 1, 0, "R4 both conditions met");
      do_wait(slot);
      chk("R5 first slot", slot, 0);
      probe(1, 0, 0, "R7 held one within lag");
      do_acq(64, slot);
      do_commit(slot, 2);
      probe(1, 0, 0, "R4 arrivals done, bytes short");
      do_tx(slot, 32);
      probe(1, 0, 0, "R4 half the bytes");
      do_tx(slot, 32);
      probe(1, 1, 0, "R4 last bytes");
      do_wait(slot);
      chk("R5 second slot", slot, 1);
      probe(1, 0, 1, "R7 held exceeds lag");
      do_rel(1, slot);
      chk("R7 released oldest", slot, 0);
      probe(1, 0, 0, "R7 back within lag");
      cons_drain = 1'b1;
      probe(1, 0, 1, "R7 drain releases remainder");
      do_rel(1, slot);
      chk("R7 drained slot", slot, 1);
      cons_drain = 1'b0;

      // R2 / R3: a full lap of acquires with nothing released, crossing the wrap
      for (int i = 0; i < S; i++) begin
         @(negedge clk); #1;
         chk("R3 slot order", int'(prod_slot), (2 + i) % S);
         fill_slot(2, 8, slot);
      end
      probe(0, 1, 0, "R2 ring full blocks acquire");
      chk("R3 wrapped slot", int'(prod_slot), 2);
      chk("R3 wrapped phase", int'(prod_phase), 0);

      // R6: drain barrier needs every consumer arrival
      do_reset(1, 2);
      for (int i = 0; i < S; i++) fill_slot(1, 16, slot);
      probe(0, 1, 0, "R2 first lap without release");
      do_wait(slot);
      do_wait(slot);
      do_rel(1, slot);
      probe(0, 1, 1, "R6 one of two consumer arrivals");
      do_rel(1, slot);
      probe(1, 1, 0, "R6 slot freed");
      chk("R6 producer back at slot 0", int'(prod_slot), 0);

      // Scenario table walk
      for (int r = 0; r < ROWS; r++) run_row(r);

      summary();
      $finish;
   end
endmodule